// File: doc/BRIEF.md
# Windowed Procedure Register File

This block is a register file whose physical array is much larger than the register set that one procedure can address. A running procedure sees one window of eight logical registers. It reaches them through two combinational read ports and one write port that is clocked on the rising edge. All three ports take logical register numbers. Inside the block, each logical number is combined with a window pointer to select a physical register.

A call strobe moves the pointer to the next window, so a called procedure gets its own set of physical registers. A return strobe moves the pointer back, and the caller finds its registers exactly as it left them. The block does not spill windows to memory or fill them from memory. When the window stack runs out at either end, the pointer stays where it is and a one-cycle flag is raised, so that an external trap handler can take over.

With the default parameters there are 16 windows of 8 registers each, 128 physical registers in total, and the data width is 32 bits. Physical index = window × 8 + logical index.

Top module: `win_regfile`

## Requirements
- R1: While `rst_n` is low at a rising edge, the window pointer returns to window 0 and both flags go low. The first register access after reset uses window 0.
- R2: A read of logical index L returns the value most recently written to logical index L while the same window was current. Windows do not share storage.
- R3: The two read ports are independent and combinational, and either port may address any logical index in the same cycle as the other.
- R4: A write is stored on the rising edge. In the cycle that carries the write, a read of the same logical index still returns the old value; there is no bypass.
- R5: A call moves the pointer from window W to W+1. Registers in the window being entered keep whatever they last held, and a call does not clear them.
- R6: A return moves the pointer from window W to W−1, and the caller's registers read back unchanged.
- R7: A call at window 15 (the last window) leaves the pointer unchanged. `ovf_o` is then high for exactly the one cycle after that edge.
- R8: A return at window 0 leaves the pointer unchanged. `unf_o` is then high for exactly the one cycle after that edge.
- R9: A cycle with call and return both high leaves the pointer unchanged and raises neither flag.
- R10: A write made in the same cycle as a call or a return goes to the window that was current before that edge.
- R11: Outside the cases in R7 and R8, both flags stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| call_i | input | 1 | Advance to the next window at this edge |
| ret_i | input | 1 | Go back to the previous window at this edge |
| we_i | input | 1 | Write enable |
| waddr_i | input | 3 | Logical register number to write |
| wdata_i | input | 32 | Data to write |
| raddr_a_i | input | 3 | Logical register number for read port A |
| raddr_b_i | input | 3 | Logical register number for read port B |
| rdata_a_o | output | 32 | Read data for port A, combinational |
| rdata_b_o | output | 32 | Read data for port B, combinational |
| ovf_o | output | 1 | One-cycle flag: a call was made at the last window |
| unf_o | output | 1 | One-cycle flag: a return was made at window 0 |

## Verification
Read data depends on the current pointer and array contents with no register in the path. The bench therefore checks both read ports 1 ns after it drives the addresses on the falling edge, before the next rising edge can apply any write, call or return from that cycle. Writes, pointer moves and the two flags take effect at the next rising edge. The bench's model updates its memory and pointer at that edge and checks the flags 1 ns later, and the effect of each write or move on read data is checked on the falling edge that follows. Directed sequences walk the pointer to both ends of the window stack and drive writes together with call or return. A long random phase follows, with both read ports compared against the model on every cycle.

// File: rtl/wrf_pkg.sv
// Package: shared types for the windowed register file.
// Assumes: call and return strobes are sampled once per rising edge.
package wrf_pkg;

    // Pointer movement requested in one cycle
    typedef enum logic [1:0] {
        WMOVE_HOLD = 2'd0,
        WMOVE_IN   = 2'd1,
        WMOVE_OUT  = 2'd2
    } wmove_e;

    // Decode the strobes; both together cancel out to a hold
    function automatic wmove_e decode_move(input logic call_s, input logic ret_s);
        wmove_e m;
        if (call_s && !ret_s)
            m = WMOVE_IN;
        else if (ret_s && !call_s)
            m = WMOVE_OUT;
        else
            m = WMOVE_HOLD;
        return m;
    endfunction

endpackage

// File: rtl/wrf_window_ctl.sv
// Module: window pointer controller.
// Moves the pointer on call/return and raises one-cycle overflow or
// underflow flags when a move would leave the window stack.
// Assumes: synchronous active-low reset; NWIN >= 2.
module wrf_window_ctl #(
    parameter int NWIN = 16,
    parameter int WPW  = $clog2(NWIN)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           call_i,
    input  logic           ret_i,
    output logic [WPW-1:0] wp_o,
    output logic           ovf_o,
    output logic           unf_o
);
    import wrf_pkg::*;

    localparam logic [WPW-1:0] WP_LAST = WPW'(NWIN - 1);

    logic [WPW-1:0] wp_q;
    logic           ovf_q;
    logic           unf_q;
    wmove_e         move;
    logic           at_last;
    logic           at_first;

    // Classify the requested move and the stack edges
    always_comb begin
        move     = decode_move(call_i, ret_i);
        at_last  = (wp_q == WP_LAST);
        at_first = (wp_q == '0);
    end

    // Pointer and flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
            case (move)
                WMOVE_IN: begin
                    if (at_last) ovf_q <= 1'b1;
                    else         wp_q  <= wp_q + WPW'(1);
                end
                WMOVE_OUT: begin
                    if (at_first) unf_q <= 1'b1;
                    else          wp_q  <= wp_q - WPW'(1);
                end
                default: ;
            endcase
        end
    end

    assign wp_o  = wp_q;
    assign ovf_o = ovf_q;
    assign unf_o = unf_q;

    // R7
    ovf_at_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> (wp_q == WP_LAST));

    // R8
    unf_at_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_q |-> (wp_q == '0));

    // R11
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_q && unf_q));

    // R9
    both_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && ret_i) |=> ($stable(wp_q) && !ovf_q && !unf_q));

    // R5
    call_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i && !at_last) |=> (wp_q == $past(wp_q) + WPW'(1)));

    // R6
    ret_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i && !at_first) |=> (wp_q == $past(wp_q) - WPW'(1)));

endmodule

// File: rtl/wrf_index_map.sv
// Module: logical-to-physical register index translation.
// Physical index = window * NLOG + logical index. Purely combinational.
// Assumes: inputs are within range (window < NWIN, logical < NLOG).
module wrf_index_map #(
    parameter int NWIN = 16,
    parameter int NLOG = 8,
    parameter int WPW  = $clog2(NWIN),
    parameter int LW   = $clog2(NLOG),
    parameter int PW   = $clog2(NWIN * NLOG)
) (
    input  logic [WPW-1:0] wp_i,
    input  logic [LW-1:0]  lidx_i,
    output logic [PW-1:0]  pidx_o
);
    // Scale the window base and add the offset
    always_comb begin
        pidx_o = PW'(wp_i) * PW'(NLOG) + PW'(lidx_i);
    end

endmodule

// File: rtl/wrf_bank.sv
// Module: physical register storage with NRD combinational read ports
// and one write port that is clocked on the rising edge.
// Assumes: indices are already translated; contents are not reset.
module wrf_bank #(
    parameter int NPHYS = 128,
    parameter int DW    = 32,
    parameter int NRD   = 2,
    parameter int IW    = $clog2(NPHYS)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [IW-1:0] widx_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [IW-1:0] ridx_i  [NRD],
    output logic [DW-1:0] rdata_o [NRD]
);
    logic [DW-1:0] regs [NPHYS];

    // Store the write data at the clock edge
    always_ff @(posedge clk) begin
        if (we_i) regs[widx_i] <= wdata_i;
    end

    // One combinational read path per port
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata_o[p] = regs[ridx_i[p]];
    end

endmodule

// File: rtl/win_regfile.sv
// Module: windowed procedure register file (top).
// Two read ports and one write port, all addressed by logical register
// number and translated through the current window pointer. Call and
// return move the pointer; the edges of the stack only raise flags.
// Assumes: synchronous active-low reset; a write uses the pointer from
// before any move made in the same cycle.
module win_regfile #(
    parameter int NWIN = 16,
    parameter int NLOG = 8,
    parameter int DW   = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    call_i,
    input  logic                    ret_i,
    input  logic                    we_i,
    input  logic [$clog2(NLOG)-1:0] waddr_i,
    input  logic [DW-1:0]           wdata_i,
    input  logic [$clog2(NLOG)-1:0] raddr_a_i,
    input  logic [$clog2(NLOG)-1:0] raddr_b_i,
    output logic [DW-1:0]           rdata_a_o,
    output logic [DW-1:0]           rdata_b_o,
    output logic                    ovf_o,
    output logic                    unf_o
);
    localparam int NPHYS = NWIN * NLOG;
    localparam int WPW   = $clog2(NWIN);
    localparam int LW    = $clog2(NLOG);
    localparam int PW    = $clog2(NPHYS);
    localparam int NRD   = 2;

    logic [WPW-1:0] wp;
    logic [PW-1:0]  widx;
    logic [LW-1:0]  rlog  [NRD];
    logic [PW-1:0]  ridx  [NRD];
    logic [DW-1:0]  rdata [NRD];

    // Gather the read addresses into a per-port array
    always_comb begin
        rlog[0] = raddr_a_i;
        rlog[1] = raddr_b_i;
    end

    wrf_window_ctl #(.NWIN(NWIN), .WPW(WPW)) u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .call_i (call_i),
        .ret_i  (ret_i),
        .wp_o   (wp),
        .ovf_o  (ovf_o),
        .unf_o  (unf_o)
    );

    wrf_index_map #(.NWIN(NWIN), .NLOG(NLOG), .WPW(WPW), .LW(LW), .PW(PW)) u_wmap (
        .wp_i   (wp),
        .lidx_i (waddr_i),
        .pidx_o (widx)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_rmap
        wrf_index_map #(.NWIN(NWIN), .NLOG(NLOG), .WPW(WPW), .LW(LW), .PW(PW)) u_rmap (
            .wp_i   (wp),
            .lidx_i (rlog[p]),
            .pidx_o (ridx[p])
        );
    end

    wrf_bank #(.NPHYS(NPHYS), .DW(DW), .NRD(NRD), .IW(PW)) u_bank (
        .clk     (clk),
        .we_i    (we_i),
        .widx_i  (widx),
        .wdata_i (wdata_i),
        .ridx_i  (ridx),
        .rdata_o (rdata)
    );

    assign rdata_a_o = rdata[0];
    assign rdata_b_o = rdata[1];

    // R1
    rst_flags_chk: assert property (@(posedge clk)
        !rst_n |=> (!ovf_o && !unf_o));

    // R3
    same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raddr_a_i == raddr_b_i) |-> (rdata_a_o == rdata_b_o));

endmodule

// File: tb/win_regfile_test.sv
// Bench: behavioural model (memory array and integer window pointer),
// compared against the design on every cycle.
module win_regfile_test;
    localparam int NWIN = 16;
    localparam int NLOG = 8;
    localparam int DW   = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          call_i = 1'b0, ret_i = 1'b0, we_i = 1'b0;
    logic [2:0]    waddr_i = '0, raddr_a_i = '0, raddr_b_i = '0;
    logic [DW-1:0] wdata_i = '0;
    logic [DW-1:0] rdata_a_o, rdata_b_o;
    logic          ovf_o, unf_o;

    int checks = 0;
    int errors = 0;

    // Model state
    logic [DW-1:0] mdl_mem [NWIN*NLOG];
    bit            mdl_wr  [NWIN*NLOG];
    int            mdl_wp = 0;
    bit            exp_ovf = 0, exp_unf = 0;

    always #5 clk = ~clk;

    win_regfile #(.NWIN(NWIN), .NLOG(NLOG), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
        .we_i(we_i), .waddr_i(waddr_i), .wdata_i(wdata_i),
        .raddr_a_i(raddr_a_i), .raddr_b_i(raddr_b_i),
        .rdata_a_o(rdata_a_o), .rdata_b_o(rdata_b_o),
        .ovf_o(ovf_o), .unf_o(unf_o)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive, check reads, apply edge to model, check flags
    task automatic step(input bit c, input bit r, input bit w, input logic [2:0] wa,
                        input logic [DW-1:0] wd, input logic [2:0] ra, input logic [2:0] rb,
                        input string rtag);
        int pa, pb;
        @(negedge clk);
        call_i = c; ret_i = r; we_i = w; waddr_i = wa; wdata_i = wd;
        raddr_a_i = ra; raddr_b_i = rb;
        #1;
        pa = mdl_wp * NLOG + int'(ra);
        pb = mdl_wp * NLOG + int'(rb);
        if (mdl_wr[pa]) chk((w && wa == ra) ? "R4" : rtag, rdata_a_o, mdl_mem[pa]);
        if (mdl_wr[pb]) chk((w && wa == rb) ? "R4" : "R3", rdata_b_o, mdl_mem[pb]);
        @(posedge clk);
        if (w) begin
            mdl_mem[mdl_wp * NLOG + int'(wa)] = wd;
            mdl_wr[mdl_wp * NLOG + int'(wa)]  = 1'b1;
        end
        exp_ovf = 0; exp_unf = 0;
        if (c && !r) begin
            if (mdl_wp == NWIN - 1) exp_ovf = 1; else mdl_wp++;
        end else if (r && !c) begin
            if (mdl_wp == 0) exp_unf = 1; else mdl_wp--;
        end
        #1;
        chk(exp_ovf ? "R7" : (c && r) ? "R9" : "R11", {31'd0, ovf_o}, {31'd0, exp_ovf});
        chk(exp_unf ? "R8" : (c && r) ? "R9" : "R11", {31'd0, unf_o}, {31'd0, exp_unf});
    endtask

    task automatic idle(input string rtag);
        step(0, 0, 0, 3'd0, '0, 3'd0, 3'd7, rtag);
    endtask

    // Read all eight registers of the current window through both ports
    task automatic sweep(input string rtag);
        for (int i = 0; i < NLOG; i++)
            step(0, 0, 0, 3'd0, '0, 3'(i), 3'(NLOG - 1 - i), rtag);
    endtask

    // Watchdog
    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NWIN*NLOG; i++) begin
            mdl_mem[i] = '0;
            mdl_wr[i]  = 1'b0;
        end
        // R1: reset state
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", {31'd0, ovf_o}, 32'd0);
        chk("R1", {31'd0, unf_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: a return right after reset must underflow (pointer at window 0)
        step(0, 1, 0, 3'd0, '0, 3'd0, 3'd0, "R1");

        // R2: fill window 0
        for (int i = 0; i < NLOG; i++)
            step(0, 0, 1, 3'(i), 32'h1000_0000 + 32'(i), 3'(i), 3'd0, "R2");
        sweep("R3");

        // R5 / R10: walk to the last window, writing during each call
        for (int d = 1; d < NWIN; d++) begin
            step(1, 0, 1, 3'd7, 32'hC000_0000 + 32'(d), 3'd0, 3'd1, "R10");
            for (int i = 0; i < NLOG - 1; i++)
                step(0, 0, 1, 3'(i), (32'(d) << 16) + 32'(i), 3'(i), 3'd7, "R5");
        end
        // window d-1 slot 7 holds the value written during the call out of it
        step(0, 0, 1, 3'd7, 32'hF000_0007, 3'd0, 3'd7, "R5");

        // R7: call at the last window, with a write in the same cycle
        step(1, 0, 1, 3'd3, 32'hDEAD_0003, 3'd3, 3'd4, "R7");
        step(0, 0, 0, 3'd0, '0, 3'd3, 3'd7, "R7");
        step(1, 0, 0, 3'd0, '0, 3'd0, 3'd1, "R7");
        idle("R11");

        // R9: both strobes together
        step(1, 1, 0, 3'd0, '0, 3'd0, 3'd1, "R9");
        sweep("R9");

        // R6: return all the way down, checking each window
        for (int d = NWIN - 1; d > 0; d--) begin
            step(0, 1, 1, 3'd6, 32'hAB00_0000 + 32'(d), 3'd6, 3'd5, "R10");
            sweep("R6");
        end
        // R8: return at window 0
        step(0, 1, 0, 3'd0, '0, 3'd0, 3'd1, "R8");
        idle("R11");
        step(1, 1, 0, 3'd0, '0, 3'd0, 3'd1, "R9");

        // R5: re-enter window 1, contents are kept
        step(1, 0, 0, 3'd0, '0, 3'd0, 3'd1, "R5");
        sweep("R5");

        // R4: no bypass of a same-cycle write
        step(0, 0, 1, 3'd2, 32'h5555_AAAA, 3'd2, 3'd2, "R4");
        step(0, 0, 0, 3'd0, '0, 3'd2, 3'd2, "R4");

        // R2: random traffic, biased so both stack ends are reached
        for (int n = 0; n < 4000; n++) begin
            int u;
            bit c, r;
            u = int'($urandom_range(0, 99));
            c = (n % 400 < 200) ? (u < 45) : (u < 10);
            r = (n % 400 < 200) ? (u >= 90) : (u >= 55);
            step(c, r, ($urandom_range(0, 1) == 1), 3'($urandom_range(0, 7)),
                 $urandom, 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)), "R2");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule